// File: doc/BRIEF.md
# Oscillator Failure Detector with Clock Fallback

This block supervises a main oscillator clock against an internal reference clock that always runs. In every measurement window of 16 reference cycles it counts main-oscillator cycles, and a separate watchdog looks for a main oscillator that has stopped toggling. If the oscillator runs too slowly, too quickly or not at all, the block records a sticky cause code. It then moves its output clock from the oscillator to the reference clock through a handshake multiplexer that never cuts a pulse short.

After reset the output runs from the reference clock. It moves to the oscillator only after two measurement windows in a row have passed both frequency limits. Once a failure has been recorded, the output stays on the reference clock until software gives a clear while the oscillator measures healthy. The interrupt output is the recorded failure gated by an enable input. The clear and enable inputs are synchronous to the reference clock.

Top module: `osc_fail_guard`

## Requirements
- R1: While reset is held and right after it is released, `clk_out` follows `ref_clk`, `on_osc` is 0, `fail_cause` is 2'b00 and `irq` is 0.
- R2: When the oscillator gives between 4 and 64 cycles (both included) per 16 reference cycles, and no failure is recorded, `on_osc` becomes 1 and `clk_out` follows `osc_clk` after two consecutive such windows.
- R3: A window with fewer than 4 oscillator cycles records cause 2'b01 (too slow) and returns `clk_out` to `ref_clk`.
- R4: A window with more than 64 oscillator cycles records cause 2'b10 (too fast) and returns `clk_out` to `ref_clk`.
- R5: No oscillator transition for 12 reference cycles records cause 2'b11 (absent). This code replaces an earlier 2'b01 or 2'b10, and `clk_out` keeps running from `ref_clk` even though the oscillator is stopped.
- R6: A recorded cause is sticky. It is not replaced by a different slow or fast verdict, and `on_osc` stays 0 even after the oscillator is healthy again, until a clear is accepted or reset is applied.
- R7: A pulse on `err_clr` is accepted only when the last completed window passed and the oscillator is not absent. An accepted clear sets `fail_cause` to 2'b00. A clear given while the oscillator is failing is ignored.
- R8: `irq` is 1 exactly when `fail_cause` is nonzero and `irq_en` is 1.
- R9: `clk_out` never has a high or low phase shorter than the shorter half-period of the two source clocks, and the two source enables are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running reference clock |
| osc_clk | input | 1 | Main oscillator clock being supervised |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_clr | input | 1 | Request to clear the recorded failure (ref_clk domain) |
| irq_en | input | 1 | Interrupt enable |
| clk_out | output | 1 | Glitch-free output clock |
| on_osc | output | 1 | 1 while the output clock is taken from the oscillator |
| fail_cause | output | 2 | Sticky cause: 00 none, 01 slow, 10 fast, 11 absent |
| irq | output | 1 | Failure interrupt |

## Verification
The bench runs the oscillator at random healthy periods between 6 and 25 ns. These show that counts inside the limits lead to a handoff onto the oscillator and that `clk_out` then tracks it. Random slow periods (60 to 90 ns), random fast periods (1.2 to 2.0 ns) and a stopped oscillator each check a different cause code. Directed sequences then separate the remaining rules: a sticky cause that outlasts a return to health, absence that overrides an earlier slow code, a clear given during a fault that is ignored, and a forced release when the oscillator stops while it is selected. A monitor measures every phase of `clk_out` to catch truncated pulses.

// File: rtl/osc_mon_pkg.sv
package osc_mon_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_SLOW   = 2'b01,
    CAUSE_FAST   = 2'b10,
    CAUSE_ABSENT = 2'b11
  } cause_e;

  // Verdict for one window: cycles counted versus inclusive healthy bounds.
  function automatic cause_e rate_verdict(input int unsigned cnt,
                                          input int unsigned lo,
                                          input int unsigned hi);
    if (cnt < lo) return CAUSE_SLOW;
    if (cnt > hi) return CAUSE_FAST;
    return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/osc_rate_meter.sv
module osc_rate_meter
  import osc_mon_pkg::*;
#(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned WIN   = 16,
  parameter int unsigned LO    = 4,
  parameter int unsigned HI    = 64
) (
  input  logic   osc_clk,
  input  logic   ref_clk,
  input  logic   rst_n,
  output logic   win_done,
  output cause_e verdict
);
  localparam int unsigned WIN_W = $clog2(WIN);

  function automatic logic [CNT_W-1:0] to_gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CNT_W-1:0] from_gray(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = int'(CNT_W) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // oscillator domain: free-running count, published in Gray code
  logic [CNT_W-1:0] osc_bin, osc_gray;
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_bin  <= '0;
      osc_gray <= '0;
    end else begin
      osc_bin  <= osc_bin + 1'b1;
      osc_gray <= to_gray(osc_bin + 1'b1);
    end
  end

  // R9 (clean crossing): the published code moves by one bit per step
  // R9
  gray_step_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $countones(osc_gray ^ $past(osc_gray)) <= 1);

  // reference domain: two-flop capture, windowed difference
  logic [CNT_W-1:0] sync_a, sync_b, prev_bin, seen_bin, delta;
  logic [WIN_W-1:0] win_pos;
  logic             win_end;

  assign seen_bin = from_gray(sync_b);
  assign delta    = seen_bin - prev_bin;
  assign win_end  = (win_pos == WIN_W'(WIN - 1));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a   <= '0;
      sync_b   <= '0;
      prev_bin <= '0;
      win_pos  <= '0;
      win_done <= 1'b0;
      verdict  <= CAUSE_NONE;
    end else begin
      sync_a   <= osc_gray;
      sync_b   <= sync_a;
      win_pos  <= win_end ? '0 : win_pos + 1'b1;
      win_done <= win_end;
      if (win_end) begin
        prev_bin <= seen_bin;
        verdict  <= rate_verdict(32'(delta), LO, HI);
      end
    end
  end

  // R3 R4: a verdict is presented only as a single-cycle pulse
  win_pulse_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    win_done |=> !win_done);

endmodule

// File: rtl/osc_toggle_watch.sv
module osc_toggle_watch #(
  parameter int unsigned LIM = 12
) (
  input  logic osc_clk,
  input  logic ref_clk,
  input  logic rst_n,
  output logic absent
);
  localparam int unsigned CW = $clog2(LIM + 1);

  logic tgl;
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) tgl <= 1'b0;
    else        tgl <= ~tgl;
  end

  logic          s1, s2, s3, edge_seen;
  logic [CW-1:0] quiet;

  assign edge_seen = s2 ^ s3;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      quiet  <= '0;
      absent <= 1'b0;
    end else begin
      s1 <= tgl; s2 <= s1; s3 <= s2;
      if (edge_seen) begin
        quiet  <= '0;
        absent <= 1'b0;
      end else if (quiet == CW'(LIM - 1)) begin
        quiet  <= CW'(LIM);
        absent <= 1'b1;
      end else if (quiet != CW'(LIM)) begin
        quiet <= quiet + 1'b1;
      end
    end
  end

  // R5
  quiet_bound_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    quiet <= CW'(LIM));

  // R5
  absent_drop_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    edge_seen |=> !absent);

endmodule

// File: rtl/glitchless_mux.sv
module glitchless_mux (
  input  logic osc_clk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic want_osc,
  input  logic force_off,
  output logic clk_out,
  output logic on_osc
);
  logic osc_rst_n, osc_q1, osc_en, ref_q1, ref_en;

  // a stopped oscillator cannot clock its own release: force it
  assign osc_rst_n = rst_n & ~force_off;

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) osc_q1 <= 1'b0;
    else            osc_q1 <= want_osc & ~ref_en;
  end

  always_ff @(negedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) osc_en <= 1'b0;
    else            osc_en <= osc_q1;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) ref_q1 <= 1'b1;
    else        ref_q1 <= ~want_osc & ~osc_en;
  end

  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) ref_en <= 1'b1;
    else        ref_en <= ref_q1;
  end

  assign clk_out = (osc_clk & osc_en) | (ref_clk & ref_en);
  assign on_osc  = osc_en;

  // R9
  mux_excl_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(ref_en && osc_en));

endmodule

// File: rtl/osc_fail_guard.sv
module osc_fail_guard
  import osc_mon_pkg::*;
#(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned WIN       = 16,
  parameter int unsigned SLOW_LIM  = 4,
  parameter int unsigned FAST_LIM  = 64,
  parameter int unsigned QUIET_LIM = 12,
  parameter int unsigned GOOD_WINS = 2
) (
  input  logic       ref_clk,
  input  logic       osc_clk,
  input  logic       rst_n,
  input  logic       err_clr,
  input  logic       irq_en,
  output logic       clk_out,
  output logic       on_osc,
  output logic [1:0] fail_cause,
  output logic       irq
);
  localparam int unsigned SW = $clog2(GOOD_WINS + 1);

  logic   win_done, absent, last_ok, want_osc, clr_ok, win_bad;
  cause_e verdict, cause_q;
  logic [SW-1:0] streak;

  osc_rate_meter #(.CNT_W(CNT_W), .WIN(WIN), .LO(SLOW_LIM), .HI(FAST_LIM)) u_meter (
    .osc_clk(osc_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .win_done(win_done), .verdict(verdict)
  );

  osc_toggle_watch #(.LIM(QUIET_LIM)) u_watch (
    .osc_clk(osc_clk), .ref_clk(ref_clk), .rst_n(rst_n), .absent(absent)
  );

  glitchless_mux u_mux (
    .osc_clk(osc_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .want_osc(want_osc), .force_off(absent),
    .clk_out(clk_out), .on_osc(on_osc)
  );

  assign win_bad = win_done && (verdict != CAUSE_NONE);
  assign clr_ok  = err_clr && last_ok && !absent && !win_bad;

  // qualification: consecutive passing windows
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      streak  <= '0;
      last_ok <= 1'b0;
    end else if (absent || win_bad) begin
      streak  <= '0;
      last_ok <= 1'b0;
    end else if (win_done) begin
      last_ok <= 1'b1;
      if (streak != SW'(GOOD_WINS)) streak <= streak + 1'b1;
    end
  end

  // sticky cause: absent overrides, otherwise first verdict kept
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q  <= CAUSE_NONE;
      want_osc <= 1'b0;
    end else begin
      if (absent)                               cause_q <= CAUSE_ABSENT;
      else if (cause_q == CAUSE_NONE && win_bad) cause_q <= verdict;
      else if (clr_ok)                          cause_q <= CAUSE_NONE;
      want_osc <= (streak == SW'(GOOD_WINS)) && (cause_q == CAUSE_NONE) && !absent;
    end
  end

  assign fail_cause = cause_q;
  assign irq        = (cause_q != CAUSE_NONE) & irq_en;

  // R5 R7
  absent_code_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    absent |=> fail_cause == 2'b11);

  // R6
  cause_hold_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fail_cause != 2'b00 && !err_clr) |=> fail_cause != 2'b00);

  // R6
  want_safe_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fail_cause != 2'b00) |=> !want_osc);

  // R3 R4
  verdict_latch_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (win_bad && cause_q == CAUSE_NONE && !absent) |=> fail_cause == $past(verdict));

endmodule

// File: tb/tb_osc_fail_guard.sv
`timescale 1ns/1ps
module tb_osc_fail_guard;
  logic ref_clk = 1'b0, osc_clk = 1'b0, rst_n = 1'b0;
  logic err_clr = 1'b0, irq_en = 1'b1;
  logic clk_out, on_osc, irq;
  logic [1:0] fail_cause;

  int  checks = 0, errors = 0, narrow = 0;
  real osc_half = 6.5;
  bit  osc_run = 1'b1;
  bit  mon_en = 1'b0;
  real last_edge = 0.0;

  osc_fail_guard dut (
    .ref_clk(ref_clk), .osc_clk(osc_clk), .rst_n(rst_n), .err_clr(err_clr),
    .irq_en(irq_en), .clk_out(clk_out), .on_osc(on_osc),
    .fail_cause(fail_cause), .irq(irq)
  );

  initial forever #5 ref_clk = ~ref_clk;
  initial forever begin
    #(osc_half);
    if (osc_run) osc_clk = ~osc_clk;
  end

  // R9: width of every output phase
  always @(clk_out) begin
    if (mon_en && ($realtime - last_edge) < 0.4) narrow++;
    last_edge = $realtime;
  end

  function automatic int exp_cause(input real period);
    real per_win;
    per_win = 160.0 / period;
    if (per_win < 4.0)  return 1;
    if (per_win > 64.0) return 2;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic pulse_clr();
    @(negedge ref_clk) err_clr = 1'b1;
    @(negedge ref_clk) err_clr = 1'b0;
  endtask

  task automatic check_state(input string req, input int cause, input bit sel);
    @(negedge ref_clk);
    #1;
    chk(int'(fail_cause) == cause, req, int'(fail_cause), cause);
    chk(on_osc == sel, req, int'(on_osc), int'(sel));
    chk(irq == ((cause != 0) && irq_en), {req, " R8"}, int'(irq), int'((cause != 0) && irq_en));
  endtask

  task automatic follow_ref(input string req);
    @(posedge ref_clk); #1;
    chk(clk_out == 1'b1, req, int'(clk_out), 1);
    @(negedge ref_clk); #1;
    chk(clk_out == 1'b0, req, int'(clk_out), 0);
  endtask

  task automatic follow_osc(input string req);
    @(posedge osc_clk); #(osc_half / 2.0);
    chk(clk_out == 1'b1, req, int'(clk_out), 1);
    @(negedge osc_clk); #(osc_half / 2.0);
    chk(clk_out == 1'b0, req, int'(clk_out), 0);
  endtask

  task automatic go_healthy(input real period);
    osc_half = period / 2.0;
    osc_run  = 1'b1;
    wait_ref(50);
    pulse_clr();
    wait_ref(80);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog R1..: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: reset state
    #20;
    chk(fail_cause == 2'b00, "R1", int'(fail_cause), 0);
    chk(on_osc == 1'b0, "R1", int'(on_osc), 0);
    chk(irq == 1'b0, "R1", int'(irq), 0);
    #27 rst_n = 1'b1;
    mon_en = 1'b1;
    wait_ref(2);
    follow_ref("R1");

    // R2: handoff onto a healthy oscillator
    wait_ref(80);
    check_state("R2", 0, 1'b1);
    follow_osc("R2");

    // R4: too fast
    osc_half = 0.75;
    wait_ref(80);
    check_state("R4", 2, 1'b0);
    follow_ref("R4");

    // R7: clear while failing is ignored
    pulse_clr();
    wait_ref(3);
    check_state("R7", 2, 1'b0);

    // R6: another failure kind does not replace the code
    osc_half = 40.0;
    wait_ref(80);
    check_state("R6", 2, 1'b0);

    // R6: healthy again but no clear
    osc_half = 6.5;
    wait_ref(100);
    check_state("R6", 2, 1'b0);

    // R8: enable gates the interrupt
    irq_en = 1'b0;
    check_state("R8", 2, 1'b0);
    irq_en = 1'b1;

    // R7: accepted clear
    pulse_clr();
    wait_ref(80);
    check_state("R7", 0, 1'b1);

    // R3: too slow, then R5: stop overrides
    osc_half = 40.0;
    wait_ref(80);
    check_state("R3", 1, 1'b0);
    osc_run = 1'b0;
    wait_ref(60);
    check_state("R5", 3, 1'b0);
    follow_ref("R5");
    pulse_clr();
    wait_ref(3);
    check_state("R7", 3, 1'b0);

    // R5: oscillator stops while it is selected (forced release)
    go_healthy(13.0);
    check_state("R2", 0, 1'b1);
    osc_run = 1'b0;
    wait_ref(60);
    check_state("R5", 3, 1'b0);
    follow_ref("R5");

    // random trials
    for (int t = 0; t < 8; t++) begin
      real hp, fp;
      int  kind, ec;
      hp = real'($urandom_range(250, 60)) / 10.0;
      go_healthy(hp);
      check_state("R2", exp_cause(hp), 1'b1);
      kind = int'($urandom_range(2, 0));
      if (kind == 0) begin
        fp = real'($urandom_range(900, 600)) / 10.0;
        osc_half = fp / 2.0;
        ec = exp_cause(fp);
        wait_ref(80);
        check_state("R3", ec, 1'b0);
      end else if (kind == 1) begin
        fp = real'($urandom_range(20, 12)) / 10.0;
        osc_half = fp / 2.0;
        ec = exp_cause(fp);
        wait_ref(80);
        check_state("R4", ec, 1'b0);
      end else begin
        osc_run = 1'b0;
        wait_ref(60);
        check_state("R5", 3, 1'b0);
      end
      follow_ref("R9");
    end

    chk(narrow == 0, "R9", narrow, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule